// File: doc/BRIEF.md
# Bit-Alias Access Bridge

The bridge sits between a bus master and a memory port. It turns accesses that land in one of two bit-alias windows into single-bit operations on ordinary memory. Every 32-bit word of a window stands for one bit of a backing region. A read through the window returns that bit as 0 or 1. A write through the window sets or clears only that bit, by means of an indivisible read-modify-write on the memory side.

Any address outside both windows goes straight through to memory unchanged. The slave side is a request/ready/done port. A sequencer (idle, read, modify-write, respond) drives the memory side, which uses a request/acknowledge handshake. The sequencer holds the slave port stalled until the current access is complete. Access sizes are byte, halfword and word. Data on both sides is right-aligned in native little-endian order.

Top module: `bitalias_bridge`

## Requirements
- R1: After reset, `s_ready` is 1, and `s_done` and `m_req` are 0.
- R2: The two windows are decoded as follows. An address in 0x22000000..0x23FFFFFF targets base 0x20000000. An address in 0x42000000..0x43FFFFFF targets base 0x40000000. The target byte address is the base ORed with the 25-bit window offset shifted right by 5.
- R3: The bit index is taken from the offset starting at offset bit 2. It is 3 bits wide for size 0 (byte), 4 bits for size 1 (halfword) and 5 bits for size 2 (word). A halfword target address has bit 0 cleared, and a word target address has bits 1:0 cleared.
- R4: An alias read returns the selected bit of the target unit in `s_rdata[0]`, with all other result bits 0.
- R5: An alias write sets the selected bit when `s_wdata[0]` is 1 and clears it when it is 0. All other bits of the unit are written back unchanged.
- R6: An alias write performs exactly one memory read and then exactly one memory write, at the same target address and size, with no other memory operation between them.
- R7: An access outside both windows makes a single memory operation with the address, size and write data unchanged. A read returns the memory data unchanged. A write response carries 0 in `s_rdata`.
- R8: The read response (`s_done`) is given in the cycle after the memory acknowledges the read.
- R9: `s_ready` falls in the cycle after a request is accepted and stays low until the response. A request held during that time is accepted only after the response and sees the memory state left by the previous access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_req | input | 1 | Slave request valid |
| s_we | input | 1 | Slave write (1) or read (0) |
| s_addr | input | 32 | Slave byte address |
| s_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| s_wdata | input | 32 | Slave write data, right-aligned |
| s_ready | output | 1 | Bridge can accept a request this cycle |
| s_done | output | 1 | One-cycle response strobe |
| s_rdata | output | 32 | Read result, valid with s_done |
| m_req | output | 1 | Memory request, held until acknowledged |
| m_we | output | 1 | Memory write (1) or read (0) |
| m_addr | output | 32 | Memory byte address |
| m_size | output | 2 | Memory access size, same encoding as s_size |
| m_wdata | output | 32 | Memory write data, right-aligned |
| m_ack | input | 1 | Memory acknowledge, one cycle per operation |
| m_rdata | input | 32 | Memory read data, valid with m_ack on reads |

## Verification
The overlap that matters is a new slave request that arrives while an alias read-modify-write is still between its memory read and its write-back. The bench provokes it by presenting every request at the very next falling edge after the previous one is accepted. The request is therefore held through the busy sequence, and the memory latency is varied over the run. The bench judges the result in three ways: it checks that `s_ready` drops right after each acceptance, it counts the memory operations per alias write, and it checks that a read queued behind a bit write returns the already-modified unit.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_MODW = 2'd2,
    ST_RESP = 2'd3
  } seq_state_e;
endpackage

// File: rtl/bitalias_decode.sv
module bitalias_decode
  import bitalias_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NWIN = 2,
  parameter int OFS_W = 25,
  parameter logic [NWIN*AW-1:0] ALIAS_BASE = '0,
  parameter logic [NWIN*AW-1:0] TGT_BASE = '0
) (
  input  logic [AW-1:0]          addr,
  input  logic [1:0]             size,
  output logic                   hit,
  output logic [AW-1:0]          tgt_addr,
  output logic [$clog2(DW)-1:0]  bit_idx
);
  localparam int BW     = $clog2(DW);
  localparam int HIGH_W = AW - OFS_W;

  logic [OFS_W-1:0] offset;
  logic [NWIN-1:0]  win_hit;
  logic [AW-1:0]    win_tgt [NWIN];
  logic [AW-1:0]    raw_tgt;
  logic [BW-1:0]    raw_idx;

  assign offset  = addr[OFS_W-1:0];
  assign raw_idx = offset[2 +: BW];

  // one comparator and one base merge per window
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_hit[w] = (addr[AW-1:OFS_W] == ALIAS_BASE[w*AW+OFS_W +: HIGH_W]);
    assign win_tgt[w] = win_hit[w] ? (TGT_BASE[w*AW +: AW] | AW'(offset >> BW)) : '0;
  end

  always_comb begin
    raw_tgt = '0;
    for (int w = 0; w < NWIN; w++) raw_tgt = raw_tgt | win_tgt[w];
  end

  always_comb begin
    hit = |win_hit;
    if (!hit) begin
      tgt_addr = addr;
    end else begin
      case (size)
        SZ_BYTE: tgt_addr = raw_tgt;
        SZ_HALF: tgt_addr = {raw_tgt[AW-1:1], 1'b0};
        default: tgt_addr = {raw_tgt[AW-1:2], 2'b00};
      endcase
    end
    case (size)
      SZ_BYTE: bit_idx = raw_idx & BW'(7);
      SZ_HALF: bit_idx = raw_idx & BW'(15);
      default: bit_idx = raw_idx;
    endcase
  end
endmodule

// File: rtl/bitalias_merge.sv
module bitalias_merge #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]         unit_val,
  input  logic [$clog2(DW)-1:0] bit_idx,
  input  logic                  set_val,
  output logic [DW-1:0]         merged,
  output logic                  bit_val
);
  logic [DW-1:0] mask;

  assign mask    = DW'(1) << bit_idx;
  assign merged  = set_val ? (unit_val | mask) : (unit_val & ~mask);
  assign bit_val = |(unit_val & mask);
endmodule

// File: rtl/bitalias_seq.sv
module bitalias_seq
  import bitalias_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_req,
  input  logic                  s_we,
  input  logic [1:0]            s_size,
  input  logic [DW-1:0]         s_wdata,
  input  logic                  dec_hit,
  input  logic [AW-1:0]         dec_addr,
  input  logic [$clog2(DW)-1:0] dec_bit,
  input  logic [DW-1:0]         merged,
  input  logic                  bit_val,
  input  logic                  m_ack,
  input  logic [DW-1:0]         m_rdata,
  output logic                  s_ready,
  output logic                  s_done,
  output logic [DW-1:0]         s_rdata,
  output logic                  m_req,
  output logic                  m_we,
  output logic [AW-1:0]         m_addr,
  output logic [1:0]            m_size,
  output logic [DW-1:0]         m_wdata,
  output logic [DW-1:0]         hold_q,
  output logic [$clog2(DW)-1:0] bit_q,
  output logic                  set_q
);
  localparam int BW = $clog2(DW);

  seq_state_e    state_q, state_d;
  logic          accept;
  logic          we_q, alias_q;
  logic [1:0]    size_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  assign accept = s_req && (state_q == ST_IDLE);
  assign set_q  = wdata_q[0];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = (s_we && !dec_hit) ? ST_MODW : ST_READ;
      ST_READ: if (m_ack)  state_d = we_q ? ST_MODW : ST_RESP;
      ST_MODW: if (m_ack)  state_d = ST_RESP;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      alias_q <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      bit_q   <= '0;
    end else if (accept) begin
      we_q    <= s_we;
      alias_q <= dec_hit;
      size_q  <= s_size;
      addr_q  <= dec_addr;
      wdata_q <= s_wdata;
      bit_q   <= dec_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             hold_q <= '0;
    else if (state_q == ST_READ && m_ack)   hold_q <= m_rdata;
  end

  always_comb begin
    s_ready = (state_q == ST_IDLE);
    s_done  = (state_q == ST_RESP);
    m_req   = (state_q == ST_READ) || (state_q == ST_MODW);
    m_we    = (state_q == ST_MODW);
    m_addr  = addr_q;
    m_size  = size_q;
    m_wdata = (state_q != ST_MODW) ? '0 : (alias_q ? merged : wdata_q);
    if (state_q != ST_RESP || we_q) s_rdata = '0;
    else                            s_rdata = alias_q ? DW'(bit_val) : hold_q;
  end

  // R8
  rd_rsp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && m_ack && !we_q) |=> s_done);

  // R6
  rmw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && m_ack && we_q) |=> (m_req && m_we && m_addr == $past(m_addr) && m_size == $past(m_size)));

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_done |-> !$past(s_ready));

  // R5
  one_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we && alias_q) |-> ($countones(m_wdata ^ hold_q) <= 1));

  // R4
  alias_rd_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_done && alias_q && !we_q) |-> (s_rdata[DW-1:1] == '0));

  // R3
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && alias_q && m_size == SZ_HALF) |-> (m_addr[0] == 1'b0));
endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
  import bitalias_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NWIN = 2,
  parameter int OFS_W = 25,
  parameter logic [NWIN*AW-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NWIN*AW-1:0] TGT_BASE   = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_req,
  input  logic          s_we,
  input  logic [AW-1:0] s_addr,
  input  logic [1:0]    s_size,
  input  logic [DW-1:0] s_wdata,
  output logic          s_ready,
  output logic          s_done,
  output logic [DW-1:0] s_rdata,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic [DW-1:0] m_wdata,
  input  logic          m_ack,
  input  logic [DW-1:0] m_rdata
);
  localparam int BW = $clog2(DW);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          dec_hit;
  logic [AW-1:0] dec_addr;
  logic [BW-1:0] dec_bit;
  logic [DW-1:0] hold_q;
  logic [BW-1:0] bit_q;
  logic          set_q;
  logic [DW-1:0] merged;
  logic          bit_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bitalias_decode #(
    .AW(AW), .DW(DW), .NWIN(NWIN), .OFS_W(OFS_W),
    .ALIAS_BASE(ALIAS_BASE), .TGT_BASE(TGT_BASE)
  ) u_decode (
    .addr(s_addr), .size(s_size),
    .hit(dec_hit), .tgt_addr(dec_addr), .bit_idx(dec_bit)
  );

  bitalias_merge #(.DW(DW)) u_merge (
    .unit_val(hold_q), .bit_idx(bit_q), .set_val(set_q),
    .merged(merged), .bit_val(bit_val)
  );

  bitalias_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .s_req(s_req), .s_we(s_we), .s_size(s_size), .s_wdata(s_wdata),
    .dec_hit(dec_hit), .dec_addr(dec_addr), .dec_bit(dec_bit),
    .merged(merged), .bit_val(bit_val),
    .m_ack(m_ack), .m_rdata(m_rdata),
    .s_ready(s_ready), .s_done(s_done), .s_rdata(s_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
    .hold_q(hold_q), .bit_q(bit_q), .set_q(set_q)
  );

  // R7
  pass_addr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (s_req && s_ready && !dec_hit) |=> (m_req && m_addr == $past(s_addr) && m_size == $past(s_size)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    s_ready |-> (!m_req && !s_done));
endmodule

// File: tb/test_bitalias_bridge.sv
module test_bitalias_bridge;
  logic        clk;
  logic        rst_n;
  logic        s_req, s_we;
  logic [31:0] s_addr, s_wdata;
  logic [1:0]  s_size;
  logic        s_ready, s_done;
  logic [31:0] s_rdata;
  logic        m_req, m_we;
  logic [31:0] m_addr, m_wdata;
  logic [1:0]  m_size;
  logic        m_ack;
  logic [31:0] m_rdata;

  int tests = 0;
  int fails = 0;

  bitalias_bridge i_bitalias_bridge (
    .clk(clk), .rst_n(rst_n),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_size(s_size), .s_wdata(s_wdata),
    .s_ready(s_ready), .s_done(s_done), .s_rdata(s_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
    .m_ack(m_ack), .m_rdata(m_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- memory model and reference copy ----------------
  logic [7:0]  mem  [0:511];
  logic [7:0]  refm [0:511];
  int          mem_lat;
  int          wcnt;
  int          rd_cnt, wr_cnt;
  logic [31:0] last_rd_addr, last_wr_addr;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) ^ (i >> 3));
  endfunction

  function automatic int midx(input logic [31:0] a, input int k);
    logic [7:0] lo;
    lo = a[7:0] + 8'(k);
    return int'({a[30], lo});
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ack   <= 1'b0;
      m_rdata <= '0;
      wcnt    <= 0;
      for (int i = 0; i < 512; i++) mem[i] <= pat(i);
    end else if (m_ack) begin
      m_ack <= 1'b0;
    end else if (m_req) begin
      if (wcnt >= mem_lat) begin
        m_ack <= 1'b1;
        wcnt  <= 0;
        if (m_we) begin
          wr_cnt       <= wr_cnt + 1;
          last_wr_addr <= m_addr;
          for (int k = 0; k < 4; k++)
            if (k < (1 << m_size)) mem[midx(m_addr, k)] <= m_wdata[8*k +: 8];
        end else begin
          rd_cnt       <= rd_cnt + 1;
          last_rd_addr <= m_addr;
          m_rdata      <= {m_size == 2'd2 ? mem[midx(m_addr,3)] : 8'h00,
                           m_size == 2'd2 ? mem[midx(m_addr,2)] : 8'h00,
                           m_size != 2'd0 ? mem[midx(m_addr,1)] : 8'h00,
                           mem[midx(m_addr,0)]};
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  function automatic logic [31:0] ref_rd(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < 4; k++)
      if (k < (1 << sz)) v[8*k +: 8] = refm[midx(a, k)];
    return v;
  endfunction

  task automatic ref_wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] v);
    for (int k = 0; k < 4; k++)
      if (k < (1 << sz)) refm[midx(a, k)] = v[8*k +: 8];
  endtask

  // independent address translation from R2/R3
  function automatic logic is_alias(input logic [31:0] a);
    return (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
  endfunction

  function automatic logic [31:0] xl_addr(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] t;
    t = (a[30] ? 32'h4000_0000 : 32'h2000_0000) | ({7'd0, a[24:0]} >> 5);
    if (sz == 2'd1) t[0] = 1'b0;
    if (sz == 2'd2) t[1:0] = 2'b00;
    return t;
  endfunction

  function automatic int xl_bit(input logic [31:0] a, input logic [1:0] sz);
    int raw;
    raw = int'(a[6:2]);
    return (sz == 2'd0) ? (raw & 7) : (sz == 2'd1) ? (raw & 15) : raw;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_q[$];
  int          ncnt = 0;
  int          rd_ack_n = -10;

  always @(negedge clk) begin
    logic [31:0] e;
    string       t;
    logic        r;
    ncnt++;
    if (rst_n && s_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected response", s_rdata, 32'h0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        r = rd_q.pop_front();
        chk(s_rdata == e, t, s_rdata, e);
        // R8: response one cycle after the read acknowledge
        if (r) chk(ncnt == rd_ack_n + 1, "R8 response timing", 32'(ncnt), 32'(rd_ack_n + 1));
      end
    end
    if (rst_n && m_ack && !m_we) rd_ack_n = ncnt;
  end

  // driver: called at a negedge, drives at once, holds until accepted
  task automatic issue(input logic we, input logic [31:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input string tag);
    logic [31:0] unit_v, exp_v, t;
    int          b;
    logic        acc;
    if (is_alias(a)) begin
      t      = xl_addr(a, sz);
      b      = xl_bit(a, sz);
      unit_v = ref_rd(t, sz);
      if (we) begin
        unit_v[b] = wd[0];
        ref_wr(t, sz, unit_v);
        exp_v = '0;
      end else begin
        exp_v = {31'd0, unit_v[b]};
      end
    end else begin
      if (we) begin
        ref_wr(a, sz, wd);
        exp_v = '0;
      end else begin
        exp_v = ref_rd(a, sz);
      end
    end
    exp_q.push_back(exp_v);
    tag_q.push_back(tag);
    rd_q.push_back(!we);
    s_req = 1'b1; s_we = we; s_addr = a; s_size = sz; s_wdata = wd;
    acc = 1'b0;
    while (!acc) begin
      acc = s_ready;
      @(negedge clk);
    end
    s_req = 1'b0;
    chk(!s_ready, "R9 ready low after accept", {31'd0, s_ready}, 32'd0);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic alias_wr(input logic [31:0] a, input logic [1:0] sz, input logic v);
    int          r0, w0;
    logic [31:0] t;
    drain();
    r0 = rd_cnt; w0 = wr_cnt;
    t  = xl_addr(a, sz);
    issue(1'b1, a, sz, {31'h7FFF_FFFE, v}, "R5 alias write response");
    drain();
    chk(rd_cnt - r0 == 1, "R6 one memory read", 32'(rd_cnt - r0), 32'd1);
    chk(wr_cnt - w0 == 1, "R6 one memory write", 32'(wr_cnt - w0), 32'd1);
    chk(last_rd_addr == t, "R6 read address", last_rd_addr, t);
    chk(last_wr_addr == t, "R6 write address", last_wr_addr, t);
    // R5: whole containing word through the pass-through path
    issue(1'b0, {t[31:2], 2'b00}, 2'd2, 32'h0, "R5 unit after alias write");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] off;
    int r0, w0;
    s_req = 1'b0; s_we = 1'b0; s_addr = '0; s_size = '0; s_wdata = '0;
    mem_lat = 0; rd_cnt = 0; wr_cnt = 0;
    last_rd_addr = '0; last_wr_addr = '0;
    for (int i = 0; i < 512; i++) refm[i] = pat(i);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1
    chk(s_ready == 1'b1, "R1 ready after reset", {31'd0, s_ready}, 32'd1);
    chk(s_done == 1'b0, "R1 done after reset", {31'd0, s_done}, 32'd0);
    chk(m_req == 1'b0, "R1 m_req after reset", {31'd0, m_req}, 32'd0);

    // R7 pass-through reads and write
    issue(1'b0, 32'h2000_0020, 2'd2, 32'h0, "R7 passthrough word read");
    issue(1'b0, 32'h4000_0012, 2'd1, 32'h0, "R7 passthrough half read");
    issue(1'b0, 32'h2000_0007, 2'd0, 32'h0, "R7 passthrough byte read");
    drain();
    r0 = rd_cnt; w0 = wr_cnt;
    issue(1'b1, 32'h2000_0040, 2'd2, 32'hDEAD_BEEF, "R7 passthrough write response");
    drain();
    chk(wr_cnt - w0 == 1 && rd_cnt == r0, "R7 single memory write", 32'(wr_cnt - w0), 32'd1);
    chk(last_wr_addr == 32'h2000_0040, "R7 write address unchanged", last_wr_addr, 32'h2000_0040);
    issue(1'b0, 32'h2000_0040, 2'd2, 32'h0, "R7 passthrough readback");

    // R2 R3 R4 alias reads, both windows, all sizes, varying latency
    for (int lat = 0; lat < 3; lat++) begin
      mem_lat = lat;
      for (int k = 0; k < 10; k++) begin
        off = (32'(k) * 32'h4C + 32'h104) & 32'h1FFC;
        for (int sz = 0; sz < 3; sz++) begin
          issue(1'b0, 32'h2200_0000 + off, 2'(sz), 32'h0, "R4 alias read low window");
          issue(1'b0, 32'h4200_0000 + off, 2'(sz), 32'h0, "R2 alias read high window");
        end
      end
    end

    // R5 R6 alias writes, set and clear, all sizes, upper index bits used
    mem_lat = 1;
    alias_wr(32'h2200_0064, 2'd2, 1'b1);
    alias_wr(32'h2200_0064, 2'd2, 1'b0);
    alias_wr(32'h4200_03F8, 2'd1, 1'b1);
    alias_wr(32'h4200_03F8, 2'd1, 1'b0);
    alias_wr(32'h2200_01DC, 2'd0, 1'b0);
    alias_wr(32'h2200_01DC, 2'd0, 1'b1);
    alias_wr(32'h4200_1FFC, 2'd2, 1'b0);
    alias_wr(32'h2200_0100, 2'd1, 1'b1);

    // R9 back-to-back: each request held while the previous one is busy
    mem_lat = 2;
    drain();
    issue(1'b1, 32'h2200_0830, 2'd2, 32'h1, "R9 queued alias write");
    issue(1'b0, 32'h2200_0830, 2'd2, 32'h0, "R9 read sees prior write");
    issue(1'b1, 32'h2200_0830, 2'd0, 32'h0, "R9 queued alias clear");
    issue(1'b0, xl_addr(32'h2200_0830, 2'd2), 2'd2, 32'h0, "R9 unit after back-to-back");
    issue(1'b0, 32'h4200_0010, 2'd0, 32'h0, "R3 byte index after stall");
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule